// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is a single DMA channel that runs a list of descriptors held in memory. Software gives the channel a chain base address and sets a doorbell. It then sets the enable bit. The engine reads a descriptor of four 32-bit words from the chain base and checks that both addresses suit the unit size. It then copies the requested number of units from the source address to the target address. When a descriptor finishes, the engine either follows a link to another descriptor in the chain or terminates and raises its interrupt.

Each descriptor holds four words, fetched in this order: command, source address, target address, count. The count word keeps the unit count in bits 23:0 and the next-descriptor offset, in 16-byte steps from the chain base, in bits 31:24. The memory side is a single-beat request interface. A request is held until it is acknowledged, and each beat moves at most one data word. A unit larger than a word therefore takes several read/write beat pairs. The port width fields of the command word are carried in the descriptor but do not change the beats on this interface.

The controlling state machine has six states:
- IDLE: waiting.
- FETCH: four descriptor reads.
- CHECK: alignment and count test.
- READ: one source beat.
- WRITE: one target beat.
- END: descriptor finished.

Its transitions are:
- IDLE→FETCH on start.
- FETCH→CHECK after the fourth word.
- CHECK→IDLE on misalignment.
- CHECK→END on a zero count.
- CHECK→READ otherwise.
- READ→WRITE on acknowledge.
- WRITE→READ for further beats.
- WRITE→END after the last beat of the last unit.
- END→FETCH when the link bit is set.
- END→IDLE when it is clear.
- Any state→IDLE on a stop write.

Top module: `dch_engine`

## Requirements
- R1: After reset the status word, the remaining count and the interrupt are zero and no memory request is made.
- R2: A transfer starts only when the enable bit (status bit 0) is written with 1 while the doorbell is set. Register selects are 0 chain base, 1 doorbell (bit 0), 2 status, 3 count. Setting enable without the doorbell shows enable=1 but makes no memory request.
- R3: The first descriptor is read from the chain base. Its four words are command, source, target and count. Only count bits 23:0 form the unit count; bits 31:24 never add to it.
- R4: Command bits 10:8 select the unit size: 0=4, 1=1, 2=2, 3=16, 4=32, 5=64, 6=128 bytes. Count×unit bytes are moved, in beats of min(unit,4) bytes.
- R5: Command bit 23 (source) and bit 22 (target) make the address advance by the beat size after each beat, and so by the unit size after each unit. With the bit clear the address stays fixed.
- R6: A finished descriptor with command bit 0 (link) set is followed by a fetch at base + offset×16. Offset 0 returns to the base, forming an endless ring.
- R7: Status bit 3 (terminated) is set, and enable cleared, only when a descriptor without the link bit completes. The interrupt follows terminated only if command bit 1 was set in that descriptor.
- R8: A source or target address that is not a multiple of the unit size sets status bit 4 (address error), clears enable, raises the interrupt and writes no data.
- R9: Writing the status register with bit 0 clear stops the channel at once and clears the status bits and the interrupt.
- R10: The count register can be written directly and always reads the units still left in the current descriptor. It is zero after a descriptor completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| stat_o | output | 5 | Status: bit 0 enable, bit 2 halt (zero), bit 3 terminated, bit 4 address error |
| remain_o | output | 24 | Units remaining in the current descriptor |
| irq_o | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_ack | input | 1 | Request accepted |
| mem_rdata | input | 32 | Read data, valid with acknowledge |

## Verification
The copy is swept over every unit size code with unit counts of 1 and 3 and all four increment combinations. The target bytes are compared with values worked out from the source pattern, which separates:
- lane placement of 1- and 2-byte beats from whole words;
- beat stepping within a unit from stepping per unit;
- fixed addresses, where only the last beat or the first source beat survives, from incrementing ones.

A guard band past the expected end catches overruns. A two-descriptor chain with a non-unit offset shows the offset scaling. A two-entry ring shows the wrap to the base and the absence of terminated status inside a chain. Misaligned, interrupt-disabled and stop-while-running cases cover the remaining status paths.

// File: rtl/dch_pkg.sv
package dch_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_CHECK,
        S_READ,
        S_WRITE,
        S_END
    } dch_state_e;

    localparam logic [1:0] SEL_BASE = 2'd0;
    localparam logic [1:0] SEL_BELL = 2'd1;
    localparam logic [1:0] SEL_STAT = 2'd2;
    localparam logic [1:0] SEL_CNT  = 2'd3;

    localparam int B_LINK = 0;
    localparam int B_TIE  = 1;
    localparam int B_USZ  = 8;
    localparam int B_DAI  = 22;
    localparam int B_SAI  = 23;

    function automatic logic [7:0] unit_bytes(input logic [2:0] code);
        case (code)
            3'd0:    return 8'd4;
            3'd1:    return 8'd1;
            3'd2:    return 8'd2;
            3'd3:    return 8'd16;
            3'd4:    return 8'd32;
            3'd5:    return 8'd64;
            default: return 8'd128;
        endcase
    endfunction

endpackage

// File: rtl/dch_unit_dec.sv
module dch_unit_dec #(
    parameter int AW = 32,
    parameter int BW = 4
) (
    input  logic [2:0]    usize,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    output logic [7:0]    unit_b,
    output logic [7:0]    beat_b,
    output logic          misalign
);
    import dch_pkg::*;

    logic [AW-1:0] mask;

    always_comb begin
        unit_b   = unit_bytes(usize);
        beat_b   = (unit_b >= 8'(BW)) ? 8'(BW) : unit_b;
        mask     = AW'(unit_b) - AW'(1);
        misalign = ((src | dst) & mask) != '0;
    end

endmodule

// File: rtl/dch_lane.sv
module dch_lane #(
    parameter int DW = 32,
    localparam int BW = DW / 8,
    localparam int LB = $clog2(BW)
) (
    input  logic [DW-1:0] rword,
    input  logic [LB-1:0] src_lo,
    input  logic [LB-1:0] dst_lo,
    input  logic [7:0]    beat_b,
    output logic [DW-1:0] wword,
    output logic [BW-1:0] be
);
    logic [DW-1:0] aligned;
    logic [BW-1:0] bmask;

    always_comb begin
        aligned = rword >> {src_lo, 3'b000};
        wword   = aligned << {dst_lo, 3'b000};
        bmask   = (beat_b >= 8'(BW)) ? '1 : BW'((1 << beat_b) - 1);
        be      = bmask << dst_lo;
    end

endmodule

// File: rtl/dch_engine.sv
module dch_engine #(
    parameter int CNT_W     = 24,
    parameter int OFS_W     = 8,
    parameter int OFS_SHIFT = 4,
    localparam int DW = CNT_W + OFS_W,
    localparam int AW = DW,
    localparam int BW = DW / 8,
    localparam int LB = $clog2(BW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_sel,
    input  logic [DW-1:0]    reg_wdata,
    output logic [4:0]       stat_o,
    output logic [CNT_W-1:0] remain_o,
    output logic             irq_o,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic [BW-1:0]    mem_be,
    input  logic             mem_ack,
    input  logic [DW-1:0]    mem_rdata
);
    import dch_pkg::*;

    dch_state_e state_q, state_d;

    logic [AW-1:0]    base_q, cur_q, src_q, dst_q;
    logic [1:0]       widx_q;
    logic             link_q, tie_q, sai_q, dai_q, tie_act_q;
    logic [2:0]       usz_q;
    logic [CNT_W-1:0] remain_q;
    logic [OFS_W-1:0] ofs_q;
    logic [7:0]       left_q;
    logic [DW-1:0]    rbuf_q;
    logic             bell_q, en_q, tt_q, ar_q;

    logic [7:0]    unit_b, beat_b;
    logic          misalign, last_beat, stop, start;
    logic [DW-1:0] lane_w;
    logic [BW-1:0] lane_be;

    dch_unit_dec #(.AW(AW), .BW(BW)) u_dec (
        .usize(usz_q), .src(src_q), .dst(dst_q),
        .unit_b(unit_b), .beat_b(beat_b), .misalign(misalign)
    );

    dch_lane #(.DW(DW)) u_lane (
        .rword(rbuf_q), .src_lo(src_q[LB-1:0]), .dst_lo(dst_q[LB-1:0]),
        .beat_b(beat_b), .wword(lane_w), .be(lane_be)
    );

    assign stop      = reg_we && (reg_sel == SEL_STAT) && !reg_wdata[0];
    assign start     = reg_we && (reg_sel == SEL_STAT) && reg_wdata[0] && bell_q
                       && (state_q == S_IDLE);
    assign last_beat = (left_q == beat_b);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_FETCH;
            S_FETCH: if (mem_ack && widx_q == 2'd3) state_d = S_CHECK;
            S_CHECK: begin
                if (misalign)               state_d = S_IDLE;
                else if (remain_q == '0)    state_d = S_END;
                else                        state_d = S_READ;
            end
            S_READ:  if (mem_ack) state_d = S_WRITE;
            S_WRITE: begin
                if (mem_ack) begin
                    if (last_beat && remain_q == CNT_W'(1)) state_d = S_END;
                    else                                    state_d = S_READ;
                end
            end
            S_END:   state_d = link_q ? S_FETCH : S_IDLE;
            default: state_d = S_IDLE;
        endcase
        if (stop) state_d = S_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath and status registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0; cur_q <= '0; src_q <= '0; dst_q <= '0;
            widx_q <= '0; link_q <= 1'b0; tie_q <= 1'b0; sai_q <= 1'b0;
            dai_q <= 1'b0; usz_q <= '0; remain_q <= '0; ofs_q <= '0;
            left_q <= '0; rbuf_q <= '0; bell_q <= 1'b0; en_q <= 1'b0;
            tt_q <= 1'b0; ar_q <= 1'b0; tie_act_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_FETCH: if (mem_ack) begin
                    widx_q <= widx_q + 2'd1;
                    unique case (widx_q)
                        2'd0: begin
                            link_q <= mem_rdata[B_LINK];
                            tie_q  <= mem_rdata[B_TIE];
                            usz_q  <= mem_rdata[B_USZ +: 3];
                            dai_q  <= mem_rdata[B_DAI];
                            sai_q  <= mem_rdata[B_SAI];
                        end
                        2'd1: src_q <= mem_rdata;
                        2'd2: dst_q <= mem_rdata;
                        default: begin
                            remain_q <= mem_rdata[CNT_W-1:0];
                            ofs_q    <= mem_rdata[DW-1:CNT_W];
                        end
                    endcase
                end
                S_CHECK: begin
                    left_q    <= unit_b;
                    tie_act_q <= tie_q;
                    if (misalign) begin
                        ar_q <= 1'b1;
                        en_q <= 1'b0;
                    end
                end
                S_READ: if (mem_ack) rbuf_q <= mem_rdata;
                S_WRITE: if (mem_ack) begin
                    if (sai_q) src_q <= src_q + AW'(beat_b);
                    if (dai_q) dst_q <= dst_q + AW'(beat_b);
                    if (last_beat) begin
                        left_q   <= unit_b;
                        remain_q <= remain_q - CNT_W'(1);
                    end else begin
                        left_q <= left_q - beat_b;
                    end
                end
                S_END: begin
                    if (link_q) begin
                        cur_q  <= base_q + (AW'(ofs_q) << OFS_SHIFT);
                        widx_q <= '0;
                    end else begin
                        tt_q <= 1'b1;
                        en_q <= 1'b0;
                    end
                end
                default: ;
            endcase

            // register writes take precedence over the sequencer
            if (reg_we) begin
                unique case (reg_sel)
                    SEL_BASE: base_q <= reg_wdata;
                    SEL_BELL: if (reg_wdata[0]) bell_q <= 1'b1;
                    SEL_CNT:  remain_q <= reg_wdata[CNT_W-1:0];
                    default: begin
                        if (!reg_wdata[0]) begin
                            en_q <= 1'b0; tt_q <= 1'b0; ar_q <= 1'b0;
                            bell_q <= 1'b0; tie_act_q <= 1'b0;
                        end else begin
                            en_q <= 1'b1;
                            if (start) begin
                                bell_q <= 1'b0; tt_q <= 1'b0; ar_q <= 1'b0;
                                cur_q  <= base_q; widx_q <= '0;
                            end
                        end
                    end
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_be    = '0;
        unique case (state_q)
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = cur_q + (AW'(widx_q) << LB);
                mem_be   = '1;
            end
            S_READ: begin
                mem_req  = 1'b1;
                mem_addr = {src_q[AW-1:LB], LB'(0)};
                mem_be   = '1;
            end
            S_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {dst_q[AW-1:LB], LB'(0)};
                mem_wdata = lane_w;
                mem_be    = lane_be;
            end
            default: ;
        endcase
        stat_o   = {ar_q, tt_q, 1'b0, 1'b0, en_q};
        remain_o = remain_q;
        irq_o    = ar_q | (tt_q & tie_act_q);
    end

    // assertions
    a_r2_start_needs_bell: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FETCH && $past(state_q) == S_IDLE) |-> $past(bell_q));

    a_r7_tt_only_unlinked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tt_q) |-> ($past(state_q) == S_END && !$past(link_q)));

    a_r8_error_from_check: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ar_q) |-> ($past(state_q) == S_CHECK));

    a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!mem_req && stat_o == 5'd0 && !irq_o));

    a_r10_remain_rises_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        (remain_q > $past(remain_q)) |->
            ($past(state_q) == S_FETCH || ($past(reg_we) && $past(reg_sel) == SEL_CNT)));

    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !stop) |=> mem_req);

endmodule

// File: tb/test_dch_engine.sv
`timescale 1ns/1ps
module test_dch_engine;
    import dch_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [1:0]  reg_sel;
    logic [31:0] reg_wdata;
    logic [4:0]  stat;
    logic [23:0] remain;
    logic        irq;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;

    logic [31:0] mem [0:1023];

    int n_chk = 0, n_fail = 0;
    int n_req = 0, n_wr = 0, n_f100 = 0, n_f120 = 0, n_tt = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dch_engine i_dch_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .stat_o(stat), .remain_o(remain), .irq_o(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr[11:2]];

    always @(posedge clk) begin
        if (mem_req && mem_we)
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        if (rst_n) begin
            if (mem_req) n_req++;
            if (mem_req && mem_we) n_wr++;
            if (mem_req && !mem_we && mem_addr == 32'h100) n_f100++;
            if (mem_req && !mem_we && mem_addr == 32'h120) n_f120++;
            if (stat[3]) n_tt++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic go();
        wr(SEL_BASE, 32'h100);
        wr(SEL_BELL, 32'h1);
        wr(SEL_STAT, 32'h1);
    endtask

    task automatic wait_end();
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (stat[3] || stat[4]) break;
        end
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    function automatic logic [7:0] byte_at(input int a);
        return mem[a >> 2][8*(a % 4) +: 8];
    endfunction

    function automatic logic [31:0] cmdw(input bit link, input bit tie, input int code,
                                         input bit sai, input bit dai);
        return 32'(link) | (32'(tie) << 1) | (32'(code) << 8) | (32'(dai) << 22)
               | (32'(sai) << 23);
    endfunction

    task automatic fill();
        for (int w = 256; w < 512; w++)
            for (int b = 0; b < 4; b++) mem[w][8*b +: 8] = pat(w * 4 + b);
        for (int w = 512; w < 768; w++) mem[w] = 32'hEEEE_EEEE;
    endtask

    task automatic put_desc(input int at, input logic [31:0] c, input logic [31:0] s,
                            input logic [31:0] d, input logic [31:0] n);
        mem[at/4] = c; mem[at/4 + 1] = s; mem[at/4 + 2] = d; mem[at/4 + 3] = n;
    endtask

    function automatic int unit_of(input int code);
        if (code == 0) return 4;
        if (code == 1) return 1;
        if (code == 2) return 2;
        return 16 << (code - 3);
    endfunction

    // count of wrong bytes in target region 0x800 against the computed copy
    function automatic int mism(input int ub, input int cnt, input bit sai, input bit dai);
        int total = ub * cnt;
        int beat  = (ub >= 4) ? 4 : ub;
        int nb    = total / beat;
        int bad   = 0;
        for (int i = 0; i < total + 4; i++) begin
            logic [7:0] e;
            int lim = dai ? total : beat;
            if (i >= lim) e = 8'hEE;
            else if (dai) e = pat(32'h400 + (sai ? i : (i % beat)));
            else e = pat(32'h400 + (sai ? ((nb - 1) * beat + i) : i));
            if (byte_at(32'h800 + i) != e) bad++;
        end
        return bad;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int c0;
        rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
        for (int w = 0; w < 1024; w++) mem[w] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(stat == 5'd0, "R1 status", 32'(stat), 0);
        chk(remain == 24'd0, "R1 remain", 32'(remain), 0);
        chk(!irq && !mem_req, "R1 irq/req", {30'd0, irq, mem_req}, 0);

        // R10 direct count write
        wr(SEL_CNT, 32'hFF00_ABCD);
        @(negedge clk);
        chk(remain == 24'h00ABCD, "R10 count write", 32'(remain), 32'hABCD);

        // R2 enable without doorbell
        fill();
        put_desc(32'h100, cmdw(0, 1, 0, 1, 1), 32'h400, 32'h800, 32'h1);
        wr(SEL_BASE, 32'h100);
        c0 = n_req;
        wr(SEL_STAT, 32'h1);
        repeat (10) @(negedge clk);
        chk(n_req == c0, "R2 no request without doorbell", n_req - c0, 0);
        chk(stat[0] == 1'b1, "R2 enable visible", 32'(stat), 1);
        wr(SEL_STAT, 32'h0);

        // R3 R4 R5 R7 R10 sweep over sizes, counts and increment modes
        for (int code = 0; code < 7; code++)
            for (int cn = 0; cn < 2; cn++)
                for (int m = 0; m < 4; m++) begin
                    int cnt = (cn == 0) ? 1 : 3;
                    bit sai = m[1];
                    bit dai = m[0];
                    int bad;
                    fill();
                    put_desc(32'h100, cmdw(0, 1, code, sai, dai), 32'h400, 32'h800,
                             {8'h5A, 24'(cnt)});
                    go();
                    wait_end();
                    bad = mism(unit_of(code), cnt, sai, dai);
                    chk(bad == 0, $sformatf("R4 R5 R3 copy code=%0d cnt=%0d sai=%0d dai=%0d",
                        code, cnt, sai, dai), bad, 0);
                    chk(stat == 5'b01000 && irq, "R7 terminated with irq",
                        {26'd0, irq, stat}, 32'h28);
                    chk(remain == 24'd0, "R10 R3 remain zero", 32'(remain), 0);
                    wr(SEL_STAT, 32'h0);
                end

        // R7 interrupt disabled
        fill();
        put_desc(32'h100, cmdw(0, 0, 2, 1, 1), 32'h400, 32'h800, 32'h2);
        go();
        wait_end();
        chk(stat[3] && !irq, "R7 no irq without enable bit", {31'd0, irq}, 0);
        wr(SEL_STAT, 32'h0);

        // R6 chain with offset 2 (0x120), R7 no terminate mid-chain
        fill();
        put_desc(32'h100, cmdw(1, 1, 0, 1, 1), 32'h400, 32'h800, {8'd2, 24'd2});
        put_desc(32'h120, cmdw(0, 1, 0, 1, 1), 32'h410, 32'h810, {8'd0, 24'd2});
        n_f120 = 0;
        go();
        wait_end();
        begin
            int bad = 0;
            for (int i = 0; i < 8; i++) begin
                if (byte_at(32'h800 + i) != pat(32'h400 + i)) bad++;
                if (byte_at(32'h810 + i) != pat(32'h410 + i)) bad++;
            end
            chk(bad == 0, "R6 chain copy", bad, 0);
        end
        chk(n_f120 == 1, "R6 next fetch at base+32", n_f120, 1);
        chk(stat[3] && irq, "R7 terminate at chain end", 32'(stat), 32'h8);
        wr(SEL_STAT, 32'h0);

        // R6 ring: offset 0 wraps to base; R7 no terminated status; R9 stop
        fill();
        put_desc(32'h100, cmdw(1, 1, 1, 1, 1), 32'h400, 32'h800, {8'd1, 24'd1});
        put_desc(32'h110, cmdw(1, 1, 1, 1, 1), 32'h401, 32'h801, {8'd0, 24'd1});
        n_f100 = 0; n_tt = 0;
        go();
        repeat (300) @(negedge clk);
        chk(n_f100 >= 3, "R6 ring returns to base", n_f100, 3);
        chk(n_tt == 0, "R7 no terminated inside ring", n_tt, 0);
        wr(SEL_STAT, 32'h0);
        c0 = n_req;
        repeat (5) @(negedge clk);
        chk(n_req == c0 && stat == 5'd0, "R9 stop halts ring", n_req - c0, 0);

        // R8 misaligned source for a 4-byte unit
        fill();
        put_desc(32'h100, cmdw(0, 0, 0, 1, 1), 32'h402, 32'h800, 32'h1);
        c0 = n_wr;
        go();
        wait_end();
        chk(stat == 5'b10000, "R8 address error status", 32'(stat), 32'h10);
        chk(irq, "R8 irq on address error", {31'd0, irq}, 1);
        chk(n_wr == c0, "R8 no data written", n_wr - c0, 0);

        // R9 stop write clears error and irq
        wr(SEL_STAT, 32'h0);
        @(negedge clk);
        chk(stat == 5'd0 && !irq, "R9 status cleared", {26'd0, irq, stat}, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule